// File: doc/BRIEF.md
# Two-Way Masked Doorbell Interrupt Controller

This block lets the two sides of a bridge interrupt each other. It holds two 16-bit doorbells. The inbound doorbell of the primary side is rung by the secondary side, and the primary side clears it. The inbound doorbell of the secondary side is rung by the primary side, and the secondary side clears it. Ringing and clearing are both write-1 operations. Each side owns a mask over its own inbound doorbell and drives one level interrupt. That interrupt is high while any set bit of the doorbell has a clear mask bit.

The two top bits of the primary-side doorbell are set only by hardware. Bit 14 is set by a one-cycle flush-complete pulse. Bit 15 is set by any change of the link-state input. A small state machine watches the link level. Its states are `LW_INIT`, `LW_LOW` and `LW_HIGH`:
- On the first clock after reset, `LW_INIT` moves to `LW_LOW` or `LW_HIGH` according to the link level and reports no change.
- A move from `LW_LOW` to `LW_HIGH` emits a change pulse.
- A move from `LW_HIGH` to `LW_LOW` also emits a change pulse.
- An invalid state code returns to `LW_INIT`.

Each side has a register port made of a write strobe, a 2-bit address, write data and read data. The address map is:
- 0 is the side's own inbound doorbell (write 1 to clear).
- 1 is the opposite side's doorbell (write 1 to ring).
- 2 is the side's own mask.
- 3 reads zero and ignores writes.

Top module: `bridge_doorbell_ctrl`

## Requirements
- R1: While reset is held, and after reset is released, both doorbells read 0x0000, both masks read 0xFFFF, and both interrupt outputs are low.
- R2: A secondary-port write to address 1 sets the primary-side doorbell bits where write data bits 13:0 are 1. Bits 15:14 of that write data are ignored.
- R3: A primary-port write to address 1 sets every secondary-side doorbell bit (15:0) whose write data bit is 1.
- R4: A write to address 0 clears each bit of the writing side's own doorbell where the data is 1. Zero data bits leave the doorbell unchanged.
- R5: When a set and a clear reach the same doorbell bit in the same cycle, the bit ends up set.
- R6: A write to address 2 replaces the writing side's mask. Each interrupt equals the OR over bits of (doorbell AND NOT mask). Masked bits still latch, so clearing a mask bit over a set doorbell bit raises the interrupt.
- R7: A one-cycle high on `flush_done` sets primary-side doorbell bit 14.
- R8: Any change of `link_up`, rising or falling, sets primary-side doorbell bit 15. The level seen on the first clock after reset is not a change.
- R9: Read data is combinational from the address: 0 gives the own doorbell, 1 the opposite doorbell, 2 the own mask, 3 zero.
- R10: A write or event sampled at a clock edge is visible on read data and on the interrupt outputs immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_wr | input | 1 | Primary port write strobe |
| pri_addr | input | 2 | Primary port register address |
| pri_wdata | input | 16 | Primary port write data |
| pri_rdata | output | 16 | Primary port read data |
| sec_wr | input | 1 | Secondary port write strobe |
| sec_addr | input | 2 | Secondary port register address |
| sec_wdata | input | 16 | Secondary port write data |
| sec_rdata | output | 16 | Secondary port read data |
| flush_done | input | 1 | One-cycle flush-complete pulse |
| link_up | input | 1 | Link-state level |
| pri_irq | output | 1 | Level interrupt to the primary side |
| sec_irq | output | 1 | Level interrupt to the secondary side |

## Verification
A ring from one port and a write-1 clear from the other port can land on the same doorbell bit in one cycle. Likewise, a flush pulse or a link toggle can coincide with software clearing bit 14 or bit 15. The bench provokes both collisions with directed steps, including a link fall in the same cycle that bit 15 is being cleared. It also mixes random writes from both ports with random events. Each outcome is judged against a bench model in which set overrides clear, comparing read data and both interrupt levels right after the edge.

// File: rtl/bdb_pkg.sv
package bdb_pkg;

    // Register port address decode, shared by both sides
    typedef enum logic [1:0] {
        REG_INBOX  = 2'd0,
        REG_OUTBOX = 2'd1,
        REG_MASK   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    // Link level watcher states
    typedef enum logic [1:0] {
        LW_INIT = 2'd0,
        LW_LOW  = 2'd1,
        LW_HIGH = 2'd2
    } lw_state_e;

endpackage

// File: rtl/db_link_watch.sv
module db_link_watch
    import bdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic chg
);

    lw_state_e st, st_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= LW_INIT;
        else        st <= st_nxt;
    end

    // Next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            LW_INIT: st_nxt = lvl ? LW_HIGH : LW_LOW;
            LW_LOW:  if (lvl)  st_nxt = LW_HIGH;
            LW_HIGH: if (!lvl) st_nxt = LW_LOW;
            default: st_nxt = LW_INIT;
        endcase
    end

    // Outputs: change pulse on either transition out of a settled state (R8)
    always_comb begin
        chg = 1'b0;
        unique case (st)
            LW_INIT: chg = 1'b0;
            LW_LOW:  chg = lvl;
            LW_HIGH: chg = !lvl;
            default: chg = 1'b0;
        endcase
    end

    // R8
    link_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != LW_INIT && !$stable(lvl)) |-> chg);

endmodule

// File: rtl/db_bank.sv
module db_bank #(
    parameter  int W       = 16,
    parameter  int HW_BITS = 0,
    localparam int HW_PW   = (HW_BITS > 0) ? HW_BITS : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     sw_set,
    input  logic [W-1:0]     sw_clr,
    input  logic [HW_PW-1:0] hw_set,
    input  logic             mask_we,
    input  logic [W-1:0]     mask_wd,
    output logic [W-1:0]     bits,
    output logic [W-1:0]     mask,
    output logic             irq
);

    logic [W-1:0] set_all;

    // Top HW_BITS positions belong to hardware events only (R2, R7, R8)
    generate
        if (HW_BITS > 0) begin : g_hw
            logic unused_sw;
            assign unused_sw = ^sw_set[W-1:W-HW_BITS];
            assign set_all   = {hw_set, sw_set[W-HW_BITS-1:0]};
        end else begin : g_nohw
            logic unused_hw;
            assign unused_hw = ^hw_set;
            assign set_all   = sw_set;
        end
    endgenerate

    // Set overrides clear (R5); reset values (R1)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
            mask <= '1;
        end else begin
            bits <= (bits & ~sw_clr) | set_all;
            if (mask_we) mask <= mask_wd;
        end
    end

    assign irq = |(bits & ~mask);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_all) |=> ((bits & $past(set_all)) == $past(set_all)));

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_clr & ~set_all)) |=> ((bits & $past(sw_clr & ~set_all)) == '0));

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!$stable(bits) || !$stable(mask)));

endmodule

// File: rtl/bridge_doorbell_ctrl.sv
module bridge_doorbell_ctrl #(
    parameter int DB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pri_wr,
    input  logic [1:0]      pri_addr,
    input  logic [DB_W-1:0] pri_wdata,
    output logic [DB_W-1:0] pri_rdata,
    input  logic            sec_wr,
    input  logic [1:0]      sec_addr,
    input  logic [DB_W-1:0] sec_wdata,
    output logic [DB_W-1:0] sec_rdata,
    input  logic            flush_done,
    input  logic            link_up,
    output logic            pri_irq,
    output logic            sec_irq
);
    import bdb_pkg::*;

    localparam int HW_EV = 2;
    localparam int SW_W  = DB_W - HW_EV;

    logic            link_chg;
    logic [DB_W-1:0] p_ring, p_clr, s_ring, s_clr;
    logic            p_mask_we, s_mask_we;
    logic [DB_W-1:0] p_bits, p_mask, s_bits, s_mask;
    reg_sel_e        p_sel, s_sel;

    assign p_sel = reg_sel_e'(pri_addr);
    assign s_sel = reg_sel_e'(sec_addr);

    db_link_watch u_link (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (link_up),
        .chg   (link_chg)
    );

    // Write decode: own inbox clears, outbox rings the far side (R2, R3, R4, R6)
    always_comb begin
        p_clr     = (pri_wr && p_sel == REG_INBOX)  ? pri_wdata : '0;
        s_ring    = (pri_wr && p_sel == REG_OUTBOX) ? pri_wdata : '0;
        p_mask_we = pri_wr && p_sel == REG_MASK;
        s_clr     = (sec_wr && s_sel == REG_INBOX)  ? sec_wdata : '0;
        p_ring    = (sec_wr && s_sel == REG_OUTBOX)
                    ? {{HW_EV{1'b0}}, sec_wdata[SW_W-1:0]} : '0;
        s_mask_we = sec_wr && s_sel == REG_MASK;
    end

    // Primary-bound doorbell: bit DB_W-2 flush, bit DB_W-1 link (R7, R8)
    db_bank #(.W(DB_W), .HW_BITS(HW_EV)) u_pbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_set  (p_ring),
        .sw_clr  (p_clr),
        .hw_set  ({link_chg, flush_done}),
        .mask_we (p_mask_we),
        .mask_wd (pri_wdata),
        .bits    (p_bits),
        .mask    (p_mask),
        .irq     (pri_irq)
    );

    db_bank #(.W(DB_W), .HW_BITS(0)) u_sbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_set  (s_ring),
        .sw_clr  (s_clr),
        .hw_set  (1'b0),
        .mask_we (s_mask_we),
        .mask_wd (sec_wdata),
        .bits    (s_bits),
        .mask    (s_mask),
        .irq     (sec_irq)
    );

    // Read mux (R9)
    function automatic logic [DB_W-1:0] rd_pick(
        input reg_sel_e        sel,
        input logic [DB_W-1:0] inbox,
        input logic [DB_W-1:0] outbox,
        input logic [DB_W-1:0] own_mask
    );
        logic [DB_W-1:0] r;
        unique case (sel)
            REG_INBOX:  r = inbox;
            REG_OUTBOX: r = outbox;
            REG_MASK:   r = own_mask;
            REG_NONE:   r = '0;
            default:    r = '0;
        endcase
        return r;
    endfunction

    assign pri_rdata = rd_pick(p_sel, p_bits, s_bits, p_mask);
    assign sec_rdata = rd_pick(s_sel, s_bits, p_bits, s_mask);

    // R2
    hw_bits_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_done && !link_chg && !p_bits[DB_W-2]) |=> !p_bits[DB_W-2]);

endmodule

// File: tb/bridge_doorbell_ctrl_test.sv
`timescale 1ns/1ps
module bridge_doorbell_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pri_wr, sec_wr, flush_done, link_up;
    logic [1:0]  pri_addr, sec_addr;
    logic [15:0] pri_wdata, sec_wdata, pri_rdata, sec_rdata;
    logic        pri_irq, sec_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model
    logic [15:0] m_pdb, m_sdb, m_pmask, m_smask;
    logic        m_prev;
    bit          m_seen;

    always #4 clk = ~clk;

    bridge_doorbell_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .pri_wr(pri_wr), .pri_addr(pri_addr), .pri_wdata(pri_wdata), .pri_rdata(pri_rdata),
        .sec_wr(sec_wr), .sec_addr(sec_addr), .sec_wdata(sec_wdata), .sec_rdata(sec_rdata),
        .flush_done(flush_done), .link_up(link_up),
        .pri_irq(pri_irq), .sec_irq(sec_irq)
    );

    function automatic logic [15:0] exp_rd(input bit sec_side, input logic [1:0] a);
        case (a)
            2'd0:    return sec_side ? m_sdb : m_pdb;
            2'd1:    return sec_side ? m_pdb : m_sdb;
            2'd2:    return sec_side ? m_smask : m_pmask;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pdb = 16'h0; m_sdb = 16'h0; m_pmask = 16'hFFFF; m_smask = 16'hFFFF;
        m_seen = 0; m_prev = 1'b0;
    endtask

    task automatic model_step();
        logic [15:0] pset, pclr, sset, sclr;
        logic        lchg;
        lchg = m_seen && (link_up != m_prev);
        m_prev = link_up; m_seen = 1;
        pset = (sec_wr && sec_addr == 2'd1) ? (sec_wdata & 16'h3FFF) : 16'h0;
        pset = pset | {lchg, flush_done, 14'h0};
        pclr = (pri_wr && pri_addr == 2'd0) ? pri_wdata : 16'h0;
        sset = (pri_wr && pri_addr == 2'd1) ? pri_wdata : 16'h0;
        sclr = (sec_wr && sec_addr == 2'd0) ? sec_wdata : 16'h0;
        m_pdb = (m_pdb & ~pclr) | pset;
        m_sdb = (m_sdb & ~sclr) | sset;
        if (pri_wr && pri_addr == 2'd2) m_pmask = pri_wdata;
        if (sec_wr && sec_addr == 2'd2) m_smask = sec_wdata;
    endtask

    // Drive, clock, update model, check after the edge (R10), return at negedge
    task automatic step(input string tag,
                        input logic pw, input logic [1:0] pa, input logic [15:0] pd,
                        input logic sw, input logic [1:0] sa, input logic [15:0] sd,
                        input logic fl, input logic lk);
        pri_wr = pw; pri_addr = pa; pri_wdata = pd;
        sec_wr = sw; sec_addr = sa; sec_wdata = sd;
        flush_done = fl; link_up = lk;
        @(posedge clk);
        model_step();
        #1;
        chk16({tag, " pri_rdata"}, pri_rdata, exp_rd(0, pa));
        chk16({tag, " sec_rdata"}, sec_rdata, exp_rd(1, sa));
        chk1({tag, " pri_irq"}, pri_irq, |(m_pdb & ~m_pmask));
        chk1({tag, " sec_irq"}, sec_irq, |(m_sdb & ~m_smask));
        @(negedge clk);
        pri_wr = 0; sec_wr = 0; flush_done = 0;
    endtask

    task automatic do_reset(input logic lk);
        rst_n = 0; pri_wr = 0; sec_wr = 0; flush_done = 0; link_up = lk;
        pri_addr = 2'd2; sec_addr = 2'd0; pri_wdata = 0; sec_wdata = 0;
        repeat (3) @(negedge clk);
        model_reset();
        #1;
        // R1
        chk16("R1 pri mask in reset", pri_rdata, 16'hFFFF);
        chk16("R1 sec inbox in reset", sec_rdata, 16'h0000);
        chk1("R1 pri_irq in reset", pri_irq, 1'b0);
        chk1("R1 sec_irq in reset", sec_irq, 1'b0);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0DB5_1C07));
        do_reset(1'b0);
        step("R1 after release", 0, 2'd2, 16'h0, 0, 2'd2, 16'h0, 0, 0);
        chk16("R1 sec mask after release", sec_rdata, 16'hFFFF);

        // R2: upper two bits of a software ring are ignored
        step("R2", 0, 2'd0, 16'h0, 1, 2'd1, 16'hFFFF, 0, 0);
        chk16("R2 ring ffff", pri_rdata, 16'h3FFF);
        chk1("R6 masked no irq", pri_irq, 1'b0);
        // R6: unmasking latched bits raises the interrupt
        step("R6", 1, 2'd2, 16'h0000, 0, 2'd0, 16'h0, 0, 0);
        chk1("R6 unmask raises irq", pri_irq, 1'b1);
        // R5: clear 00ff while bit 0 is rung in the same cycle
        step("R5", 1, 2'd0, 16'h00FF, 1, 2'd1, 16'h0001, 0, 0);
        chk16("R5 set beats clear", pri_rdata, 16'h3F01);
        // R3
        step("R3", 1, 2'd1, 16'h8001, 0, 2'd0, 16'h0, 0, 0);
        chk16("R3 sec ring", sec_rdata, 16'h8001);
        chk1("R6 sec still masked", sec_irq, 1'b0);
        // R4
        step("R4", 0, 2'd3, 16'h0, 1, 2'd0, 16'h0001, 0, 0);
        chk16("R4 sec w1c", sec_rdata, 16'h8000);
        chk16("R9 addr3 reads zero", pri_rdata, 16'h0000);
        step("R4 zeros", 1, 2'd0, 16'h0000, 0, 2'd1, 16'h0, 0, 0);
        chk16("R4 zero write no effect", pri_rdata, 16'h3F01);
        // R7
        step("R7", 0, 2'd0, 16'h0, 0, 2'd0, 16'h0, 1, 0);
        chk16("R7 flush sets bit14", pri_rdata, 16'h7F01);
        // R8: rise, clear, then fall during a clear of bit 15
        step("R8", 0, 2'd0, 16'h0, 0, 2'd0, 16'h0, 0, 1);
        chk16("R8 rise sets bit15", pri_rdata, 16'hFF01);
        step("R8", 1, 2'd0, 16'h8000, 0, 2'd0, 16'h0, 0, 1);
        chk16("R8 bit15 cleared", pri_rdata, 16'h7F01);
        step("R8", 1, 2'd0, 16'h8000, 0, 2'd0, 16'h0, 0, 0);
        chk16("R8 fall beats clear (R5)", pri_rdata, 16'hFF01);
        step("R7", 1, 2'd0, 16'h4000, 0, 2'd0, 16'h0, 1, 0);
        chk16("R7 flush beats clear", pri_rdata, 16'hFF01);
        // R6: masking all again drops the interrupt
        step("R6", 1, 2'd2, 16'hFFFF, 0, 2'd0, 16'h0, 0, 0);
        chk1("R6 remask drops irq", pri_irq, 1'b0);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic lk;
            lk = ($urandom_range(0, 9) == 0) ? ~link_up : link_up;
            step("R6 R9 random",
                 ($urandom_range(0, 1) == 1), 2'($urandom_range(0, 3)), 16'($urandom),
                 ($urandom_range(0, 1) == 1), 2'($urandom_range(0, 3)), 16'($urandom),
                 ($urandom_range(0, 9) == 0), lk);
        end

        // R8: link held high through reset is not a change
        do_reset(1'b1);
        step("R8 init", 0, 2'd0, 16'h0, 0, 2'd1, 16'h0, 0, 1);
        step("R8 init", 0, 2'd0, 16'h0, 0, 2'd1, 16'h0, 0, 1);
        chk16("R8 no event after reset", pri_rdata, 16'h0000);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule